// File: doc/BRIEF.md
# Chunk-Serial Mantissa Adder Stage

This block is one macro-stage of a variable-precision floating-point pipeline. It adds two mantissas that are already aligned, with the same sign and the same exponent. Each mantissa is up to eight 64-bit chunks long, and the stage handles it one chunk per clock through a 64-bit adder. An operand record arrives over a valid/ready handshake. The record holds the two mantissas, the number of chunks each one uses, the sign and exponent, and a working-precision limit. The stage copies the mantissas into its input buffers and the sign and exponent into a flip-flop barrier beside them. The limit is captured in the same cycle.

The stage walks from the least significant used chunk toward chunk 0 and carries between iterations. The number of cycles equals the longer operand's chunk count. When the sum is longer than the working precision, the discarded low chunks are processed first. Their round and sticky information is therefore known when the first kept chunk is reached. Round-to-nearest-even is applied in that same cycle, with no second pass. The result record holds the kept chunks, an integer-bit field with the hidden bits and the carry-out, and a guard field for the next stage. It is held at the output until the consumer takes it.

Top module: `chunk_add_stage`

## Requirements
- R1: After reset, `in_ready_o` is 1 and `out_valid_o` is 0.
- R2: An operand record is accepted on a rising edge where `in_valid_i` and `in_ready_o` are both high. From that edge until the edge where `out_ready_i` takes the result, `in_ready_o` stays low, and anything driven on the input side during that time has no effect on the result.
- R3: Lengths and working precision are clamped to the range 1..8 (0 reads as 1, values above 8 read as 8). `out_valid_o` rises exactly N clock edges after the accepting edge, where N is the larger of the two clamped operand lengths.
- R4: Chunk k of every mantissa bus sits at bits [64k+63:64k], and chunk 0 is the most significant. The result chunks are the chunk-wise sum with carries propagated toward chunk 0. `res_int_o` equals 2 (the two hidden bits) plus the carry out of chunk 0, so it can be 2, 3 or 4.
- R5: Input chunks at index ≥ an operand's length read as zero, whatever the bus carries. A shorter operand is therefore zero-extended at its low end.
- R6: `res_len_o` = min(N, W), where W is the clamped working precision sampled on the accepting edge. Later changes of `wp_i` have no effect on the result.
- R7: If N > W, the result is rounded to nearest even. The round bit is bit 63 of sum chunk W. Sticky is the OR of all lower discarded bits. One unit is added at chunk W-1 when round AND (sticky OR lsb of chunk W-1). The increment carries on toward chunk 0 and into `res_int_o`.
- R8: `res_guard_o[7:1]` carries bits 63..57 of unrounded sum chunk W. `res_guard_o[0]` is the OR of bits 56..0 of that chunk and all chunks above index W. With no truncation the guard field is 0. Result chunks at index ≥ `res_len_o` are 0.
- R9: `res_sign_o` and `res_exp_o` equal `sign_i` and `exp_i` as sampled on the accepting edge.
- R10: While `out_valid_o` is high and `out_ready_i` is low, the result record and `out_valid_o` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand record valid |
| in_ready_o | output | 1 | Stage can accept a record |
| a_len_i | input | 4 | Chunks used by operand A |
| a_mant_i | input | 512 | Operand A mantissa, chunk k at [64k+63:64k] |
| b_len_i | input | 4 | Chunks used by operand B |
| b_mant_i | input | 512 | Operand B mantissa |
| sign_i | input | 1 | Common sign (side info) |
| exp_i | input | 16 | Common exponent (side info) |
| wp_i | input | 4 | Working precision in chunks |
| out_valid_o | output | 1 | Result record valid |
| out_ready_i | input | 1 | Consumer takes the result |
| res_len_o | output | 4 | Result chunk count |
| res_mant_o | output | 512 | Result mantissa |
| res_int_o | output | 3 | Integer bits: hidden bits plus carry |
| res_guard_o | output | 8 | Guard bits below the last kept chunk |
| res_sign_o | output | 1 | Sign passed through |
| res_exp_o | output | 16 | Exponent passed through |

## Verification
The hardest case to reach is a rounding increment that meets a pending inter-chunk carry in the same first kept chunk. This makes a carry of two, which ripples into the integer bits. The stimulus adds two all-ones mantissas of two chunks with a working precision of one. The round bit and sticky are then both set, the lsb is odd, and the incoming carry is one, so the expected integer field is 4. Ties to even are covered from both sides by sum chunks whose discarded part is exactly one half. A late change of the working precision and illegal input traffic while the stage is busy check that only the accepting edge matters.

// File: rtl/chunk_add_pkg.sv
package chunk_add_pkg;
  localparam int unsigned DEF_CHUNK_W    = 64;
  localparam int unsigned DEF_MAX_CHUNKS = 8;
  localparam int unsigned DEF_EXP_W      = 16;
  localparam int unsigned DEF_GUARD_W    = 8;
  localparam int unsigned DEF_INT_W      = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } seq_state_e;

  // counts of zero read as one, counts above hi read as hi
  function automatic logic [7:0] clamp_cnt(input logic [7:0] v, input logic [7:0] hi);
    if (v == 8'd0)    return 8'd1;
    else if (v > hi)  return hi;
    else              return v;
  endfunction
endpackage

// File: rtl/chunk_op_buf.sv
module chunk_op_buf #(
  parameter int unsigned CHUNK_W    = 64,
  parameter int unsigned MAX_CHUNKS = 8,
  localparam int unsigned LEN_W     = $clog2(MAX_CHUNKS + 1),
  localparam int unsigned IDX_W     = $clog2(MAX_CHUNKS),
  localparam int unsigned BUS_W     = CHUNK_W * MAX_CHUNKS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [BUS_W-1:0]   mant_i,
  input  logic [IDX_W-1:0]   sel_i,
  output logic [CHUNK_W-1:0] chunk_o
);
  logic [CHUNK_W-1:0] mem_q [MAX_CHUNKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < MAX_CHUNKS; k++) mem_q[k] <= '0;
    end else if (load_i) begin
      for (int k = 0; k < MAX_CHUNKS; k++) begin
        // unused chunks are stored as zero
        mem_q[k] <= (LEN_W'(k) < len_i) ? mant_i[k*CHUNK_W +: CHUNK_W] : '0;
      end
    end
  end

  assign chunk_o = mem_q[sel_i];
endmodule

// File: rtl/chunk_add_seq.sv
module chunk_add_seq
  import chunk_add_pkg::*;
#(
  parameter int unsigned MAX_CHUNKS = 8,
  localparam int unsigned LEN_W     = $clog2(MAX_CHUNKS + 1),
  localparam int unsigned IDX_W     = $clog2(MAX_CHUNKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             out_ready_i,
  input  logic [LEN_W-1:0] a_len_i,
  input  logic [LEN_W-1:0] b_len_i,
  input  logic [LEN_W-1:0] wp_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic             load_o,
  output logic             step_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [LEN_W-1:0] rl_o,
  output logic [LEN_W-1:0] n_o
);
  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] n_q, rl_q, wp_q, cnt_q;
  logic [LEN_W-1:0] n_new, rl_new;

  assign in_ready_o  = (state_q == ST_IDLE);
  assign out_valid_o = (state_q == ST_HOLD);
  assign load_o      = in_valid_i && in_ready_o;
  assign step_o      = (state_q == ST_RUN);
  assign idx_o       = idx_q;
  assign rl_o        = rl_q;
  assign n_o         = n_q;

  assign n_new  = (a_len_i > b_len_i) ? a_len_i : b_len_i;
  assign rl_new = (n_new < wp_i) ? n_new : wp_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load_o) state_d = ST_RUN;
      ST_RUN:  if (idx_q == '0) state_d = ST_HOLD;
      ST_HOLD: if (out_ready_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      n_q     <= '0;
      rl_q    <= '0;
      wp_q    <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        n_q   <= n_new;
        rl_q  <= rl_new;
        wp_q  <= wp_i;
        idx_q <= IDX_W'(n_new - 1'b1);
        cnt_q <= '0;
      end else if (step_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (idx_q != '0) idx_q <= idx_q - 1'b1;
      end
    end
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> (cnt_q == n_q)); // R3

  AST_LEN_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (rl_q != '0) && (rl_q <= wp_q) && (rl_q <= n_q)); // R6

  AST_HOLD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(rl_q)); // R10

  AST_STEP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (LEN_W'(idx_q) < n_q)); // R3
endmodule

// File: rtl/chunk_add_dp.sv
module chunk_add_dp #(
  parameter int unsigned CHUNK_W    = 64,
  parameter int unsigned MAX_CHUNKS = 8,
  parameter int unsigned GUARD_W    = 8,
  parameter int unsigned INT_W      = 3,
  localparam int unsigned LEN_W     = $clog2(MAX_CHUNKS + 1),
  localparam int unsigned IDX_W     = $clog2(MAX_CHUNKS),
  localparam int unsigned BUS_W     = CHUNK_W * MAX_CHUNKS,
  localparam int unsigned SUM_W     = CHUNK_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [LEN_W-1:0]   rl_i,
  input  logic [LEN_W-1:0]   n_i,
  input  logic [CHUNK_W-1:0] a_chunk_i,
  input  logic [CHUNK_W-1:0] b_chunk_i,
  output logic [BUS_W-1:0]   res_mant_o,
  output logic [GUARD_W-1:0] res_guard_o,
  output logic [INT_W-1:0]   res_int_o
);
  logic [CHUNK_W-1:0] res_q [MAX_CHUNKS];
  logic [1:0]         carry_q;
  logic               round_q, sticky_q;
  logic [GUARD_W-1:0] guard_q;
  logic [INT_W-1:0]   int_q;

  logic [LEN_W-1:0]   idx_ext;
  logic               trunc, kept, at_rl, round_pt, inc;
  logic [SUM_W-1:0]   sum_raw, sum_fin;
  logic [CHUNK_W-1:0] sum_c;
  logic [1:0]         carry_out;

  assign idx_ext  = LEN_W'(idx_i);
  assign trunc    = n_i > rl_i;
  assign kept     = idx_ext < rl_i;
  assign at_rl    = idx_ext == rl_i;
  assign round_pt = trunc && (idx_ext == rl_i - 1'b1);

  // carry can reach 2 when a rounding increment meets an incoming carry
  assign sum_raw   = SUM_W'(a_chunk_i) + SUM_W'(b_chunk_i) + SUM_W'(carry_q);
  assign inc       = round_pt && round_q && (sticky_q || sum_raw[0]);
  assign sum_fin   = sum_raw + SUM_W'(inc);
  assign sum_c     = sum_fin[CHUNK_W-1:0];
  assign carry_out = sum_fin[SUM_W-1:CHUNK_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < MAX_CHUNKS; k++) res_q[k] <= '0;
      carry_q  <= '0;
      round_q  <= 1'b0;
      sticky_q <= 1'b0;
      guard_q  <= '0;
      int_q    <= '0;
    end else if (load_i) begin
      for (int k = 0; k < MAX_CHUNKS; k++) res_q[k] <= '0;
      carry_q  <= '0;
      round_q  <= 1'b0;
      sticky_q <= 1'b0;
      guard_q  <= '0;
      int_q    <= '0;
    end else if (step_i) begin
      carry_q <= carry_out;
      if (kept) begin
        res_q[idx_i] <= sum_c;
      end else if (at_rl) begin
        round_q  <= sum_c[CHUNK_W-1];
        sticky_q <= sticky_q | (|sum_c[CHUNK_W-2:0]);
        guard_q  <= {sum_c[CHUNK_W-1 -: GUARD_W-1],
                     sticky_q | (|sum_c[CHUNK_W-GUARD_W:0])};
      end else begin
        sticky_q <= sticky_q | (|sum_c);
      end
      if (idx_i == '0) int_q <= INT_W'(2) + INT_W'(carry_out);
    end
  end

  for (genvar g = 0; g < MAX_CHUNKS; g++) begin : g_res
    assign res_mant_o[g*CHUNK_W +: CHUNK_W] = res_q[g];
  end
  assign res_guard_o = guard_q;
  assign res_int_o   = int_q;

  AST_CARRY_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_q <= 2'd2); // R4

  AST_NO_ROUND_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !trunc |-> !round_q && !sticky_q && (guard_q == '0)); // R8

  AST_INC_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && inc |-> kept); // R7
endmodule

// File: rtl/chunk_add_stage.sv
module chunk_add_stage
  import chunk_add_pkg::*;
#(
  parameter int unsigned CHUNK_W    = DEF_CHUNK_W,
  parameter int unsigned MAX_CHUNKS = DEF_MAX_CHUNKS,
  parameter int unsigned EXP_W      = DEF_EXP_W,
  parameter int unsigned GUARD_W    = DEF_GUARD_W,
  parameter int unsigned INT_W      = DEF_INT_W,
  localparam int unsigned LEN_W     = $clog2(MAX_CHUNKS + 1),
  localparam int unsigned IDX_W     = $clog2(MAX_CHUNKS),
  localparam int unsigned BUS_W     = CHUNK_W * MAX_CHUNKS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [LEN_W-1:0]   a_len_i,
  input  logic [BUS_W-1:0]   a_mant_i,
  input  logic [LEN_W-1:0]   b_len_i,
  input  logic [BUS_W-1:0]   b_mant_i,
  input  logic               sign_i,
  input  logic [EXP_W-1:0]   exp_i,
  input  logic [LEN_W-1:0]   wp_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [LEN_W-1:0]   res_len_o,
  output logic [BUS_W-1:0]   res_mant_o,
  output logic [INT_W-1:0]   res_int_o,
  output logic [GUARD_W-1:0] res_guard_o,
  output logic               res_sign_o,
  output logic [EXP_W-1:0]   res_exp_o
);
  logic [LEN_W-1:0]   a_len_c, b_len_c, wp_c, rl, n_tot;
  logic               load, step;
  logic [IDX_W-1:0]   idx;
  logic [CHUNK_W-1:0] a_chunk, b_chunk;
  logic               sign_q;
  logic [EXP_W-1:0]   exp_q;

  assign a_len_c = LEN_W'(clamp_cnt(8'(a_len_i), 8'(MAX_CHUNKS)));
  assign b_len_c = LEN_W'(clamp_cnt(8'(b_len_i), 8'(MAX_CHUNKS)));
  assign wp_c    = LEN_W'(clamp_cnt(8'(wp_i),    8'(MAX_CHUNKS)));

  chunk_add_seq #(.MAX_CHUNKS(MAX_CHUNKS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .a_len_i     (a_len_c),
    .b_len_i     (b_len_c),
    .wp_i        (wp_c),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .load_o      (load),
    .step_o      (step),
    .idx_o       (idx),
    .rl_o        (rl),
    .n_o         (n_tot)
  );

  chunk_op_buf #(.CHUNK_W(CHUNK_W), .MAX_CHUNKS(MAX_CHUNKS)) u_buf_a (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .len_i   (a_len_c),
    .mant_i  (a_mant_i),
    .sel_i   (idx),
    .chunk_o (a_chunk)
  );

  chunk_op_buf #(.CHUNK_W(CHUNK_W), .MAX_CHUNKS(MAX_CHUNKS)) u_buf_b (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .len_i   (b_len_c),
    .mant_i  (b_mant_i),
    .sel_i   (idx),
    .chunk_o (b_chunk)
  );

  chunk_add_dp #(
    .CHUNK_W(CHUNK_W), .MAX_CHUNKS(MAX_CHUNKS),
    .GUARD_W(GUARD_W), .INT_W(INT_W)
  ) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .step_i      (step),
    .idx_i       (idx),
    .rl_i        (rl),
    .n_i         (n_tot),
    .a_chunk_i   (a_chunk),
    .b_chunk_i   (b_chunk),
    .res_mant_o  (res_mant_o),
    .res_guard_o (res_guard_o),
    .res_int_o   (res_int_o)
  );

  // side-information barrier
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sign_q <= 1'b0;
      exp_q  <= '0;
    end else if (load) begin
      sign_q <= sign_i;
      exp_q  <= exp_i;
    end
  end

  assign res_sign_o = sign_q;
  assign res_exp_o  = exp_q;
  assign res_len_o  = rl;

  AST_READY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !out_valid_o); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> $stable(res_mant_o) && $stable(res_guard_o)
      && $stable(res_int_o) && $stable(res_exp_o) && $stable(res_sign_o)); // R10

  AST_SIDE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> $stable(res_exp_o) && $stable(res_sign_o)); // R9

  AST_INT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (res_int_o >= INT_W'(2)) && (res_int_o <= INT_W'(4))); // R4
endmodule

// File: tb/chunk_add_stage_bench.sv
module chunk_add_stage_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 64;
  localparam int MC = 8;
  localparam int BW = CW * MC;
  localparam int WD_CYCLES = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [3:0]    a_len = '0, b_len = '0, wp = '0;
  logic [BW-1:0] a_mant = '0, b_mant = '0;
  logic          sign = 1'b0;
  logic [15:0]   exp_v = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [3:0]    res_len;
  logic [BW-1:0] res_mant;
  logic [2:0]    res_int;
  logic [7:0]    res_guard;
  logic          res_sign;
  logic [15:0]   res_exp;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chunk_add_stage u_chunk_add_stage (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .a_len_i(a_len), .a_mant_i(a_mant),
    .b_len_i(b_len), .b_mant_i(b_mant),
    .sign_i(sign), .exp_i(exp_v), .wp_i(wp),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .res_len_o(res_len), .res_mant_o(res_mant), .res_int_o(res_int),
    .res_guard_o(res_guard), .res_sign_o(res_sign), .res_exp_o(res_exp)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int clampc(input int v);
    if (v < 1) return 1;
    if (v > MC) return MC;
    return v;
  endfunction

  // reference from the requirement text
  task automatic model(input logic [BW-1:0] a, input logic [BW-1:0] b,
                       input int la, input int lb, input int n, input int rl,
                       output logic [BW-1:0] m, output logic [7:0] g, output int ic);
    logic [63:0] s [MC];
    logic [64:0] t;
    int c;
    bit r, st, inc, cy;
    c = 0;
    for (int k = 0; k < MC; k++) s[k] = '0;
    for (int k = n - 1; k >= 0; k--) begin
      t = 65'(k < la ? a[k*CW +: CW] : 64'd0) + 65'(k < lb ? b[k*CW +: CW] : 64'd0) + 65'(c);
      s[k] = t[63:0];
      c = int'(t[64]);
    end
    g = '0;
    if (n > rl) begin
      r  = s[rl][63];
      st = |s[rl][62:0];
      for (int j = rl + 1; j < n; j++) st = st | (|s[j]);
      g = {s[rl][63:57], 1'b0};
      g[0] = |s[rl][56:0];
      for (int j = rl + 1; j < n; j++) g[0] = g[0] | (|s[j]);
      inc = r && (st || s[rl-1][0]);
      if (inc) begin
        cy = 1'b1;
        for (int k = rl - 1; k >= 0; k--) begin
          if (cy) begin
            s[k] = s[k] + 64'd1;
            cy = (s[k] == 64'd0);
          end
        end
        if (cy) c = c + 1;
      end
    end
    m = '0;
    for (int k = 0; k < rl; k++) m[k*CW +: CW] = s[k];
    ic = 2 + c;
  endtask

  task automatic run_case(input string req, input int la, input int lb,
                          input logic [BW-1:0] a, input logic [BW-1:0] b,
                          input int wpv, input int hold, input bit late_wp, input bit bogus);
    int lac, lbc, wpc, n, rl, lat, ic;
    logic [BW-1:0] em, saved;
    logic [7:0] eg;
    logic [15:0] ex;
    logic sg;
    bit busy_ok, hold_ok;
    lac = clampc(la); lbc = clampc(lb); wpc = clampc(wpv);
    n  = (lac > lbc) ? lac : lbc;
    rl = (n < wpc) ? n : wpc;
    model(a, b, lac, lbc, n, rl, em, eg, ic);
    sg = la[0] ^ wpv[0];
    ex = 16'(la * 1000 + lb * 37 + wpv * 3 + 5);

    @(negedge clk);
    a_len = 4'(la); b_len = 4'(lb); a_mant = a; b_mant = b;
    wp = 4'(wpv); sign = sg; exp_v = ex; in_valid = 1'b1; out_ready = 1'b0;
    check(in_ready == 1'b1, "R2", "ready before accept", BW'(in_ready), BW'(1));
    @(posedge clk);
    @(negedge clk);
    if (bogus) begin
      a_mant = ~a; b_mant = ~b; a_len = 4'd8; b_len = 4'd8;
      wp = 4'd1; sign = ~sg; exp_v = ~ex;
    end else begin
      in_valid = 1'b0;
    end
    if (late_wp) wp = (wpc == MC) ? 4'd1 : 4'd8;

    lat = 0;
    busy_ok = 1'b1;
    while (!out_valid && lat < 20) begin
      if (in_ready) busy_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    if (in_ready) busy_ok = 1'b0;
    check(lat == n, "R3", "latency", BW'(lat), BW'(n));

    saved = res_mant;
    hold_ok = 1'b1;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      if (!out_valid || res_mant !== saved || in_ready) hold_ok = 1'b0;
    end
    check(hold_ok, "R10", "held result", saved, res_mant);
    check(busy_ok, "R2", "ready low while busy", BW'(busy_ok), BW'(1));

    check(res_len == 4'(rl), "R6", "result length", BW'(res_len), BW'(rl));
    check(res_mant === em, req, "result mantissa", res_mant, em);
    check(res_int == 3'(ic), "R4", "integer bits", BW'(res_int), BW'(ic));
    check(res_guard == eg, "R8", "guard bits", BW'(res_guard), BW'(eg));
    check(res_sign == sg && res_exp == ex, "R9", "sign/exponent",
          BW'({res_sign, res_exp}), BW'({sg, ex}));

    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R2", "released after take",
          BW'({out_valid, in_ready}), BW'(2'b01));
  endtask

  function automatic logic [BW-1:0] ones(input int cnt);
    logic [BW-1:0] v;
    v = '0;
    for (int k = 0; k < cnt; k++) v[k*CW +: CW] = '1;
    return v;
  endfunction

  task automatic t_reset();
    check(in_ready == 1'b1, "R1", "ready after reset", BW'(in_ready), BW'(1));
    check(out_valid == 1'b0, "R1", "valid after reset", BW'(out_valid), BW'(0));
  endtask

  task automatic t_basic();
    logic [BW-1:0] a, b;
    a = '0; b = '0;
    a[0 +: CW] = 64'h1234_5678_9abc_def0; a[CW +: CW] = 64'h8000_0000_0000_0001;
    b[0 +: CW] = 64'h0101_0101_0101_0101; b[CW +: CW] = 64'h8000_0000_0000_0002;
    run_case("R4", 2, 2, a, b, 8, 0, 1'b0, 1'b0);
  endtask

  task automatic t_mixed_len();
    logic [BW-1:0] a, b;
    a = '0;
    a[0 +: CW] = 64'h0f0f; a[CW +: CW] = 64'hffff_ffff_0000_0000; a[2*CW +: CW] = 64'hdead_beef;
    b = {8{64'hcafe_f00d_5555_aaaa}}; // garbage above length 1
    run_case("R5", 3, 1, a, b, 8, 0, 1'b0, 1'b0);
    run_case("R5", 1, 3, b, a, 8, 0, 1'b0, 1'b0);
  endtask

  task automatic t_carry_chain();
    logic [BW-1:0] b;
    b = '0; b[3*CW +: CW] = 64'd1;
    run_case("R4", 4, 4, ones(4), b, 8, 0, 1'b0, 1'b0);
  endtask

  task automatic t_round();
    logic [BW-1:0] a, b;
    // tie, kept lsb even: no increment
    a = '0; b = '0;
    a[CW +: CW] = 64'h10; a[2*CW +: CW] = 64'h8000_0000_0000_0000; a[0 +: CW] = 64'h7;
    run_case("R7", 3, 1, a, b, 2, 0, 1'b0, 1'b0);
    // tie, kept lsb odd: increment
    a[CW +: CW] = 64'h11;
    run_case("R7", 3, 1, a, b, 2, 0, 1'b0, 1'b0);
    // above half: increment
    a[CW +: CW] = 64'h10; a[2*CW +: CW] = 64'h8000_0000_0000_0001;
    run_case("R7", 3, 1, a, b, 2, 0, 1'b0, 1'b0);
    // below half: no increment, sticky in guard
    a[2*CW +: CW] = 64'h7fff_0000_0000_0001;
    run_case("R7", 3, 1, a, b, 2, 0, 1'b0, 1'b0);
    // rounding ripples through an all-ones kept chunk into a carry of two
    run_case("R7", 2, 2, ones(2), ones(2), 1, 0, 1'b0, 1'b0);
    // long truncation, sticky from deep chunks only
    a = '0; b = '0;
    a[0 +: CW] = 64'h3; a[CW +: CW] = 64'h4000_0000_0000_0000; a[7*CW +: CW] = 64'h1;
    b[CW +: CW] = 64'h4000_0000_0000_0000;
    run_case("R8", 8, 2, a, b, 1, 0, 1'b0, 1'b0);
  endtask

  task automatic t_wp_late();
    run_case("R6", 4, 3, ones(4), ones(3), 2, 0, 1'b1, 1'b0);
  endtask

  task automatic t_busy_ignore();
    logic [BW-1:0] a, b;
    a = '0; b = '0;
    a[0 +: CW] = 64'h5; a[CW +: CW] = 64'h9;
    b[CW +: CW] = 64'h3;
    run_case("R2", 2, 2, a, b, 8, 3, 1'b0, 1'b1);
  endtask

  task automatic t_hold();
    run_case("R10", 5, 5, ones(5), ones(2), 3, 6, 1'b0, 1'b0);
  endtask

  task automatic t_clamp();
    logic [BW-1:0] a, b;
    a = '0; b = '0;
    a[0 +: CW] = 64'hffff_ffff_ffff_fffe; b[0 +: CW] = 64'h3;
    run_case("R3", 0, 0, a, b, 0, 0, 1'b0, 1'b0);
    run_case("R3", 8, 15, ones(8), {8{64'h0123_4567_89ab_cdef}}, 15, 0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R3 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mixed_len();
    t_carry_chain();
    t_round();
    t_wp_late();
    t_busy_ignore();
    t_hold();
    t_clamp();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule